// File: doc/BRIEF.md
# Coded Frame Decoder with Error Detection

This block sits on the receive side of a serial link, after clock recovery and deserialization. Once per frame strobe it accepts one coded frame: a 4-bit control field above a 20-bit data field. It sorts the frame into one of three kinds: a data word, a control word or an idle fill frame. It restores data words that were sent complemented and delivers the result on a parallel output with qualifying indicators. A frame whose encoding matches none of the legal forms raises an error indication instead.

The word width is chosen per frame: 16 bits in narrow mode or 20 bits in wide mode. A flag bit travels with every data frame. If the user enables it, the flag carries user information. If the user leaves it disabled, the decoder expects the flag to toggle between successive data frames and treats a repeat as a transmission error. All outputs change only on frame strobes, two frames after the frame that produced them.

Top module: `frameDecoder`

## Requirements
- R1: After reset, dataOut is zero and dataAvail, ctrlAvail, fillOut, errOut and flagOut are all 0.
- R2: A frame presented with frame strobe number n appears on the outputs right after the clock edge of strobe n+2, and the outputs do not change on clock edges without a strobe.
- R3: A control field of 01IF (bit 1 = I, bit 0 = F) is a data frame. It yields dataAvail=1 and flagOut=F. dataOut is the data field when I=0, or its bitwise complement when I=1, limited to the mode width.
- R4: Control field 1000 is a control frame. It yields ctrlAvail=1, and dataOut is the low 14 (narrow) or 18 (wide) data bits, zero-extended. If any data bit between the payload and the mode width is nonzero, the frame is an error instead.
- R5: Control fields 1100 and 1101 are fill frames. They yield fillOut=1 with dataAvail=ctrlAvail=0, and dataOut and flagOut keep their previous values. A fill frame whose data bits within the mode width are not all ones is an error instead.
- R6: Any other control field (00xx, 1001 to 1011, 1110, 1111) yields errOut=1 with dataAvail, ctrlAvail and fillOut at 0, and dataOut and flagOut held.
- R7: With flagEn=0, a data frame whose flag equals the flag of the directly preceding data frame yields errOut=1 and dataAvail=0, with dataOut held. That frame's flag becomes the reference for the next one.
- R8: After any frame that is not data-coded (fill, control or illegal), the next data frame is accepted with either flag value and becomes the new reference.
- R9: With flagEn=1, repeated flag values are accepted and no alternation error is raised.
- R10: In narrow mode (wideMode=0), data-field bits 19 to 16 of a data frame are ignored and dataOut bits 19 to 16 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | Marks the cycle in which frameIn holds a new frame |
| frameIn | input | 24 | Coded frame: bits 23:20 control field, bits 19:0 data field |
| wideMode | input | 1 | 1 = 20-bit words, 0 = 16-bit words; sampled with the frame |
| flagEn | input | 1 | 1 = flag carries user data, 0 = flag alternation is checked; sampled with the frame |
| dataOut | output | 20 | Decoded data or control payload |
| dataAvail | output | 1 | Output frame is a valid data word |
| ctrlAvail | output | 1 | Output frame is a valid control word |
| fillOut | output | 1 | Output frame is a valid fill frame |
| flagOut | output | 1 | Flag of the last valid data frame |
| errOut | output | 1 | Output frame was illegal or broke flag alternation |

## Verification
A corrupted flag reference in the control part shows up exactly two strobes after the next data frame. It appears as a spurious errOut with a missing dataAvail, or as a missed error on a repeated flag. Scenarios therefore put fill and control frames between data frames and repeat flags. A slip in the pipeline gating moves every indicator by one frame, so each strobe compares all six outputs, and so does the idle cycle after it. A wrong hold on fill or error frames leaves a stale or zero dataOut that the following check exposes.

// File: rtl/frame_dec_pkg.sv
package frame_dec_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_DATA = 3'd1,
    K_CTRL = 3'd2,
    K_FILL = 3'd3,
    K_ERR  = 3'd4
  } frameKind_t;

  // Strobes from the control part to the datapath for the frame in stage 1.
  typedef struct packed {
    frameKind_t kind;
    logic       invert;
    logic       flagBit;
    logic       wide;
  } decStrobe_t;

endpackage

// File: rtl/frameCtrl.sv
module frameCtrl
  import frame_dec_pkg::*;
#(
  parameter int WideW   = 20,
  parameter int NarrowW = 16,
  parameter int CtlDrop = 2,
  parameter int CfW     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic               s1Valid,
  input  logic [CfW-1:0]     s1CField,
  input  logic [WideW-1:0]   s1DField,
  input  logic               s1Wide,
  input  logic               s1FlagEn,
  output decStrobe_t         dec
);

  localparam logic [WideW-1:0] WideMask      = {WideW{1'b1}};
  localparam logic [WideW-1:0] NarrowMask    = WideMask >> (WideW - NarrowW);
  localparam logic [WideW-1:0] CtlWideMask   = WideMask >> CtlDrop;
  localparam logic [WideW-1:0] CtlNarrowMask = WideMask >> (WideW - NarrowW + CtlDrop);

  logic             refValid;
  logic             refFlag;
  logic [WideW-1:0] modeMask;
  logic [WideW-1:0] ctlMask;
  logic             isDataCode;
  logic             altBad;

  assign modeMask   = s1Wide ? WideMask : NarrowMask;
  assign ctlMask    = s1Wide ? CtlWideMask : CtlNarrowMask;
  assign isDataCode = (s1CField[CfW-1:CfW-2] == 2'b01);
  assign altBad     = !s1FlagEn && refValid && (s1CField[0] == refFlag);

  always_comb begin
    dec.invert  = s1CField[1];
    dec.flagBit = s1CField[0];
    dec.wide    = s1Wide;
    dec.kind    = K_ERR;
    if (!s1Valid) begin
      dec.kind = K_NONE;
    end else begin
      casez (s1CField)
        4'b01??: dec.kind = altBad ? K_ERR : K_DATA;
        4'b1000: dec.kind = ((s1DField & modeMask & ~ctlMask) != '0) ? K_ERR : K_CTRL;
        4'b110?: dec.kind = ((s1DField & modeMask) != modeMask) ? K_ERR : K_FILL;
        default: dec.kind = K_ERR;
      endcase
    end
  end

  // Alternation reference: set by data-coded frames, cleared by anything else.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refValid <= 1'b0;
      refFlag  <= 1'b0;
    end else if (advance && s1Valid) begin
      if (isDataCode) begin
        refValid <= 1'b1;
        refFlag  <= s1CField[0];
      end else begin
        refValid <= 1'b0;
      end
    end
  end

  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(advance) |-> ($stable(refValid) && $stable(refFlag))); // R8

endmodule

// File: rtl/frameDatapath.sv
module frameDatapath
  import frame_dec_pkg::*;
#(
  parameter int WideW   = 20,
  parameter int NarrowW = 16,
  parameter int CtlDrop = 2,
  parameter int CfW     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameStrobe,
  input  logic [WideW+CfW-1:0]  frameIn,
  input  logic                  wideMode,
  input  logic                  flagEn,
  input  decStrobe_t            dec,
  output logic                  s1Valid,
  output logic [CfW-1:0]        s1CField,
  output logic [WideW-1:0]      s1DField,
  output logic                  s1Wide,
  output logic                  s1FlagEn,
  output logic [WideW-1:0]      dataOut,
  output logic                  dataAvail,
  output logic                  ctrlAvail,
  output logic                  fillOut,
  output logic                  flagOut,
  output logic                  errOut
);

  localparam logic [WideW-1:0] WideMask      = {WideW{1'b1}};
  localparam logic [WideW-1:0] NarrowMask    = WideMask >> (WideW - NarrowW);
  localparam logic [WideW-1:0] CtlWideMask   = WideMask >> CtlDrop;
  localparam logic [WideW-1:0] CtlNarrowMask = WideMask >> (WideW - NarrowW + CtlDrop);

  frameKind_t       s2Kind;
  logic [WideW-1:0] s2Payload;
  logic             s2Flag;
  logic             s2Wide;
  logic             outWide;
  logic [WideW-1:0] nextPayload;

  // Stage 1: raw capture.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1CField <= '0;
      s1DField <= '0;
      s1Wide   <= 1'b0;
      s1FlagEn <= 1'b0;
    end else if (frameStrobe) begin
      s1Valid  <= 1'b1;
      s1CField <= frameIn[WideW+CfW-1:WideW];
      s1DField <= frameIn[WideW-1:0];
      s1Wide   <= wideMode;
      s1FlagEn <= flagEn;
    end
  end

  always_comb begin
    nextPayload = '0;
    if (dec.kind == K_DATA) begin
      nextPayload = (dec.invert ? ~s1DField : s1DField) &
                    (dec.wide ? WideMask : NarrowMask);
    end else if (dec.kind == K_CTRL) begin
      nextPayload = s1DField & (dec.wide ? CtlWideMask : CtlNarrowMask);
    end
  end

  // Stage 2: decoded frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Kind    <= K_NONE;
      s2Payload <= '0;
      s2Flag    <= 1'b0;
      s2Wide    <= 1'b0;
    end else if (frameStrobe) begin
      s2Kind    <= dec.kind;
      s2Payload <= nextPayload;
      s2Flag    <= dec.flagBit;
      s2Wide    <= dec.wide;
    end
  end

  // Stage 3: user-facing outputs.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataAvail <= 1'b0;
      ctrlAvail <= 1'b0;
      fillOut   <= 1'b0;
      flagOut   <= 1'b0;
      errOut    <= 1'b0;
      outWide   <= 1'b0;
    end else if (frameStrobe) begin
      dataAvail <= (s2Kind == K_DATA);
      ctrlAvail <= (s2Kind == K_CTRL);
      fillOut   <= (s2Kind == K_FILL);
      errOut    <= (s2Kind == K_ERR);
      outWide   <= s2Wide;
      if (s2Kind == K_DATA) begin
        dataOut <= s2Payload;
        flagOut <= s2Flag;
      end else if (s2Kind == K_CTRL) begin
        dataOut <= s2Payload;
      end
    end
  end

  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameStrobe) |-> ($stable(dataOut) && $stable(dataAvail) && $stable(ctrlAvail)
                             && $stable(fillOut) && $stable(errOut) && $stable(flagOut))); // R2
  AST_FILL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    fillOut |-> ($stable(dataOut) && $stable(flagOut))); // R5
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $stable(dataOut)); // R6
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlAvail |-> (dataOut[WideW-1:WideW-CtlDrop] == '0)); // R4
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && !outWide) |-> (dataOut[WideW-1:NarrowW] == '0)); // R10

endmodule

// File: rtl/frameDecoder.sv
module frameDecoder
  import frame_dec_pkg::*;
#(
  parameter int WideW   = 20,
  parameter int NarrowW = 16,
  parameter int CtlDrop = 2,
  parameter int CfW     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStrobe,
  input  logic [WideW+CfW-1:0] frameIn,
  input  logic                 wideMode,
  input  logic                 flagEn,
  output logic [WideW-1:0]     dataOut,
  output logic                 dataAvail,
  output logic                 ctrlAvail,
  output logic                 fillOut,
  output logic                 flagOut,
  output logic                 errOut
);

  decStrobe_t       dec;
  logic             s1Valid;
  logic [CfW-1:0]   s1CField;
  logic [WideW-1:0] s1DField;
  logic             s1Wide;
  logic             s1FlagEn;

  frameCtrl #(
    .WideW(WideW), .NarrowW(NarrowW), .CtlDrop(CtlDrop), .CfW(CfW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .advance  (frameStrobe),
    .s1Valid  (s1Valid),
    .s1CField (s1CField),
    .s1DField (s1DField),
    .s1Wide   (s1Wide),
    .s1FlagEn (s1FlagEn),
    .dec      (dec)
  );

  frameDatapath #(
    .WideW(WideW), .NarrowW(NarrowW), .CtlDrop(CtlDrop), .CfW(CfW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .frameStrobe (frameStrobe),
    .frameIn     (frameIn),
    .wideMode    (wideMode),
    .flagEn      (flagEn),
    .dec         (dec),
    .s1Valid     (s1Valid),
    .s1CField    (s1CField),
    .s1DField    (s1DField),
    .s1Wide      (s1Wide),
    .s1FlagEn    (s1FlagEn),
    .dataOut     (dataOut),
    .dataAvail   (dataAvail),
    .ctrlAvail   (ctrlAvail),
    .fillOut     (fillOut),
    .flagOut     (flagOut),
    .errOut      (errOut)
  );

endmodule

// File: tb/frameDecoder_bench.sv
module frameDecoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0;
  logic [23:0] frameIn = '0;
  logic        wideMode = 1'b0;
  logic        flagEn = 1'b0;
  logic [19:0] dataOut;
  logic        dataAvail, ctrlAvail, fillOut, flagOut, errOut;

  always #10 clk = ~clk;

  frameDecoder u_frameDecoder (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .frameIn(frameIn),
    .wideMode(wideMode), .flagEn(flagEn), .dataOut(dataOut),
    .dataAvail(dataAvail), .ctrlAvail(ctrlAvail), .fillOut(fillOut),
    .flagOut(flagOut), .errOut(errOut)
  );

  int total = 0;
  int bad = 0;
  int n = 0;
  bit finished = 1'b0;

  logic [19:0] eData [0:255];
  logic [4:0]  eBits [0:255]; // {dav, cav, fill, err, flag}
  string       eTag  [0:255];

  // Reference state, from the requirements
  logic        mRefValid = 1'b0;
  logic        mRefFlag = 1'b0;
  logic [19:0] mData = '0;
  logic        mFlag = 1'b0;

  task automatic predict(input string tag, input logic [3:0] c, input logic [19:0] d,
                         input logic w, input logic fe);
    logic [19:0] mask;
    logic [19:0] cmask;
    logic dav, cav, fil, err;
    mask  = w ? 20'hFFFFF : 20'h0FFFF;
    cmask = w ? 20'h3FFFF : 20'h03FFF;
    dav = 0; cav = 0; fil = 0; err = 0;
    if (c[3:2] == 2'b01) begin
      if (!fe && mRefValid && c[0] == mRefFlag) err = 1;
      else begin
        dav = 1;
        mData = (c[1] ? ~d : d) & mask;
        mFlag = c[0];
      end
      mRefValid = 1; mRefFlag = c[0];
    end else begin
      mRefValid = 0;
      if (c == 4'b1000) begin
        if ((d & mask & ~cmask) != 0) err = 1;
        else begin cav = 1; mData = d & cmask; end
      end else if (c[3:1] == 3'b110) begin
        if ((d & mask) != mask) err = 1;
        else fil = 1;
      end else err = 1;
    end
    eData[n] = mData;
    eBits[n] = {dav, cav, fil, err, mFlag};
    eTag[n]  = tag;
  endtask

  task automatic checkOut(input int k, input string extra);
    logic [19:0] xd;
    logic [4:0]  xb;
    string tg;
    if (k < 0) begin xd = '0; xb = '0; tg = "R1"; end
    else begin xd = eData[k]; xb = eBits[k]; tg = eTag[k]; end
    total++;
    if (dataOut !== xd || {dataAvail, ctrlAvail, fillOut, errOut, flagOut} !== xb) begin
      bad++;
      $display("FAIL %s%s: got data=%h dav/cav/fill/err/flag=%b, expected data=%h bits=%b",
               tg, extra, dataOut, {dataAvail, ctrlAvail, fillOut, errOut, flagOut}, xd, xb);
    end
  endtask

  task automatic sendFrame(input string tag, input logic [3:0] c, input logic [19:0] d,
                           input logic w, input logic fe);
    predict(tag, c, d, w, fe);
    @(negedge clk);
    frameIn = {c, d}; wideMode = w; flagEn = fe; frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0; frameIn = {4'b0000, 20'h5A5A5};
    checkOut(n - 2, "");
    @(negedge clk);
    checkOut(n - 2, " (R2 no-strobe hold)");
    n++;
  endtask

  task automatic flush();
    sendFrame("R5", 4'b1100, 20'hFFFFF, 1'b1, 1'b0);
    sendFrame("R5", 4'b1101, 20'hFFFFF, 1'b1, 1'b0);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkOut(-1, " reset");
  endtask

  task automatic testDataNarrow();
    sendFrame("R3", 4'b0100, 20'h01234, 1'b0, 1'b0);
    sendFrame("R3", 4'b0111, 20'h0BEEF, 1'b0, 1'b0);
    sendFrame("R10", 4'b0100, 20'hF1357, 1'b0, 1'b0);
    flush();
  endtask

  task automatic testDataWide();
    sendFrame("R3", 4'b0101, 20'hABCDE, 1'b1, 1'b0);
    sendFrame("R3", 4'b0110, 20'h12345, 1'b1, 1'b0);
    sendFrame("R2", 4'b0101, 20'h00F0F, 1'b1, 1'b0);
    flush();
  endtask

  task automatic testControl();
    sendFrame("R4", 4'b1000, 20'h03ABC, 1'b0, 1'b0);
    sendFrame("R4", 4'b1000, 20'h3FFFF, 1'b1, 1'b0);
    sendFrame("R4", 4'b1000, 20'h04000, 1'b0, 1'b0);
    sendFrame("R4", 4'b1000, 20'h40001, 1'b1, 1'b0);
    sendFrame("R4", 4'b1000, 20'hF0001, 1'b0, 1'b0);
    flush();
  endtask

  task automatic testFill();
    sendFrame("R3", 4'b0101, 20'h77777, 1'b1, 1'b0);
    sendFrame("R5", 4'b1100, 20'hFFFFF, 1'b1, 1'b0);
    sendFrame("R5", 4'b1101, 20'h0FFFF, 1'b0, 1'b0);
    sendFrame("R5", 4'b1100, 20'h0FFFF, 1'b1, 1'b0);
    sendFrame("R5", 4'b1101, 20'hFFFEF, 1'b0, 1'b0);
    flush();
  endtask

  task automatic testIllegal();
    sendFrame("R3", 4'b0110, 20'h00055, 1'b0, 1'b0);
    sendFrame("R6", 4'b0000, 20'h11111, 1'b0, 1'b0);
    sendFrame("R6", 4'b0011, 20'h22222, 1'b1, 1'b0);
    sendFrame("R6", 4'b1001, 20'h33333, 1'b1, 1'b0);
    sendFrame("R6", 4'b1010, 20'h44444, 1'b1, 1'b0);
    sendFrame("R6", 4'b1011, 20'h55555, 1'b1, 1'b0);
    sendFrame("R6", 4'b1110, 20'hFFFFF, 1'b1, 1'b0);
    sendFrame("R6", 4'b1111, 20'hFFFFF, 1'b1, 1'b0);
    flush();
  endtask

  task automatic testAlternation();
    sendFrame("R7", 4'b0100, 20'h0A001, 1'b0, 1'b0);
    sendFrame("R7", 4'b0101, 20'h0A002, 1'b0, 1'b0);
    sendFrame("R7", 4'b0101, 20'h0A003, 1'b0, 1'b0);
    sendFrame("R7", 4'b0100, 20'h0A004, 1'b0, 1'b0);
    sendFrame("R7", 4'b0110, 20'h0A005, 1'b0, 1'b0);
    flush();
  endtask

  task automatic testRestart();
    sendFrame("R8", 4'b0101, 20'h0B001, 1'b1, 1'b0);
    sendFrame("R8", 4'b1000, 20'h00123, 1'b1, 1'b0);
    sendFrame("R8", 4'b0101, 20'h0B002, 1'b1, 1'b0);
    sendFrame("R8", 4'b1111, 20'h00000, 1'b1, 1'b0);
    sendFrame("R8", 4'b0111, 20'h0B003, 1'b1, 1'b0);
    sendFrame("R8", 4'b1100, 20'hFFFFF, 1'b1, 1'b0);
    sendFrame("R8", 4'b0101, 20'h0B004, 1'b1, 1'b0);
    flush();
  endtask

  task automatic testFlagEnabled();
    sendFrame("R9", 4'b0101, 20'h0C001, 1'b0, 1'b1);
    sendFrame("R9", 4'b0101, 20'h0C002, 1'b0, 1'b1);
    sendFrame("R9", 4'b0100, 20'h0C003, 1'b0, 1'b1);
    sendFrame("R9", 4'b0110, 20'h0C004, 1'b0, 1'b1);
    flush();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDataNarrow();
    testDataWide();
    testControl();
    testFill();
    testIllegal();
    testAlternation();
    testRestart();
    testFlagEnabled();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule